// File: doc/BRIEF.md
# BCD calendar clock counter

This block holds a running time of day and calendar as seven packed-BCD bytes: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year counted from 2000. A prescaler counts pulses on a tick input. After every `TICKS_PER_SEC` pulses one second is added, and the carry runs through all fields in the same clock cycle. Month lengths follow a simple leap rule: a year value divisible by four is a leap year.

A single write port loads the fields, with a mask on each field. A one-bit display mode sits at a separate control address. The mode picks between a 24-hour hour byte and a 12-hour hour byte with a PM flag. The hour is always stored in 24-hour form, so changing the mode changes only how the hour byte is shown. Writing any time field resets the prescaler, so the next second comes one full second after the write. All seven fields are shown in parallel on snapshot outputs. A separate block provides the bus front end that drives the write port.

The design has no multi-state controller. Field selection is an enumerated decode (`FLD_SEC`, `FLD_MIN`, `FLD_HOUR`, `FLD_WDAY`, `FLD_MDAY`, `FLD_MONTH`, `FLD_YEAR`, `FLD_NONE`), and the carry chain is combinational.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs read 00 seconds, 00 minutes, midnight, weekday 1, day 01, month 01 and year 00. The mode bit is clear, which selects 12-hour display, so the hour byte reads 8'h12.
- R2: The seconds field advances by one on the clock edge that samples the `TICKS_PER_SEC`-th tick pulse since the prescaler was last cleared. Between such edges, with no write, no field changes.
- R3: Seconds go from 59 to 00 and add one to minutes. Minutes go from 59 to 00 and add one to hours.
- R4: Hours go from 23 to 00 and advance both the day of month and the weekday. The weekday counts 1 to 7 and then wraps to 1.
- R5: The day of month rolls to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 (including 00) and 28 days otherwise. All other months have 31 days. Month 12 rolls to 01 and increments the year, and year 99 rolls to 00.
- R6: The control address is 15, and bit 5 there is the mode bit. When it is 1, the hour byte shows BCD 00–23 and an hour write takes data bits 5:0 as BCD 00–23.
- R7: When the mode bit is 0, hour byte bit 5 is the PM flag and bits 4:0 hold BCD 1–12. Midnight shows 8'h12 and noon shows 8'h32.
- R8: In 12-hour mode an hour write takes bits 4:0 as BCD 1–12 and bit 5 as PM. 12 with PM clear stores hour 0, and 12 with PM set stores hour 12. Any other PM value adds twelve.
- R9: The field addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month and 6 year. The bits kept on write are 6:0, 6:0, (per mode), 2:0, 5:0, 4:0 and 7:0, and all other bits are stored as zero.
- R10: A write to any of addresses 0–6 clears the prescaler. A tick in the same cycle is discarded. A write to the control address leaves the prescaler unchanged.
- R11: Writes to addresses 7–14 change no output.
- R12: Changing the mode bit leaves the stored time unchanged. Switching back restores the previous hour byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sub-second pulse counted by the prescaler |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address (0–6 time fields, 15 control) |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte, encoded per mode |
| wday_o | output | 8 | Weekday 1–7 |
| mday_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within century, BCD |

## Verification
The write port and the seconds carry pass through one register, so every result appears after the clock edge that samples the stimulus. The bench applies stimulus at a falling edge and holds it for one full cycle. It clears the stimulus and compares at the next falling edge, which comes half a period after the result is registered. A second completes on the edge that samples the last tick pulse, so the reference model advances in the same task call that drives that pulse. A mode change takes effect on the hour byte one edge after the control write, because the display encoding is combinational from the stored mode.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
        bcd8_t wday;
        bcd8_t mday;
        bcd8_t month;
        bcd8_t year;
    } cal_t;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_MDAY  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } field_e;

    // add one to a two-digit BCD value, carrying into the tens digit
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(bcd8_t v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic bcd8_t bin_to_bcd(logic [7:0] b);
        return {4'(b / 8'd10), 4'(b % 8'd10)};
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic sec_pulse_o
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse_o = tick_i && !clr_i && (cnt_q == LAST);

    AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q)) else $error("prescaler moved without tick"); // R2
    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)) else $error("prescaler not cleared by field write"); // R10

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);
    logic  c_min, c_hour, c_day, c_mon, c_year;
    logic  leap;
    bcd8_t dim;

    // divisible by four in BCD: even tens with 0/4/8, odd tens with 2/6
    always_comb begin
        if (cur_i.year[4]) begin
            leap = (cur_i.year[3:0] == 4'd2) || (cur_i.year[3:0] == 4'd6);
        end else begin
            leap = (cur_i.year[3:0] == 4'd0) || (cur_i.year[3:0] == 4'd4) ||
                   (cur_i.year[3:0] == 4'd8);
        end
        unique case (cur_i.month)
            8'h02:                      dim = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
            default:                    dim = 8'h31;
        endcase
    end

    always_comb begin
        nxt_o  = cur_i;
        c_min  = cur_i.sec >= 8'h59;
        c_hour = c_min && (cur_i.min >= 8'h59);
        c_day  = c_hour && (cur_i.hour >= 8'h23);
        c_mon  = c_day && (cur_i.mday >= dim);
        c_year = c_mon && (cur_i.month >= 8'h12);

        nxt_o.sec = c_min ? 8'h00 : bcd_inc(cur_i.sec);
        if (c_min) begin
            nxt_o.min = c_hour ? 8'h00 : bcd_inc(cur_i.min);
        end
        if (c_hour) begin
            nxt_o.hour = c_day ? 8'h00 : bcd_inc(cur_i.hour);
        end
        if (c_day) begin
            nxt_o.mday = c_mon ? 8'h01 : bcd_inc(cur_i.mday);
            nxt_o.wday = (cur_i.wday >= 8'h07) ? 8'h01 : cur_i.wday + 8'h01;
        end
        if (c_mon) begin
            nxt_o.month = c_year ? 8'h01 : bcd_inc(cur_i.month);
        end
        if (c_year) begin
            nxt_o.year = (cur_i.year >= 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
        end
    end

endmodule

// File: rtl/cal_hour_codec.sv
module cal_hour_codec
    import cal_pkg::*;
(
    input  logic       mode24_i,
    input  bcd8_t      hour24_i,
    input  logic [5:0] wdata_i,
    output bcd8_t      disp_o,
    output bcd8_t      wr_hour24_o
);
    logic [7:0] hb;
    logic [7:0] wb;

    // stored 24-hour value to display byte
    always_comb begin
        hb = bcd_to_bin(hour24_i);
        if (mode24_i) begin
            disp_o = hour24_i;
        end else if (hb == 8'd0) begin
            disp_o = 8'h12;
        end else if (hb < 8'd12) begin
            disp_o = bin_to_bcd(hb);
        end else if (hb == 8'd12) begin
            disp_o = 8'h32;
        end else begin
            disp_o = 8'h20 | bin_to_bcd(hb - 8'd12);
        end
    end

    // written byte to stored 24-hour value
    always_comb begin
        wb = bcd_to_bin({3'b000, wdata_i[4:0]}) + (wdata_i[5] ? 8'd12 : 8'd0);
        if (mode24_i) begin
            wr_hour24_o = {2'b00, wdata_i};
        end else if (wb == 8'd12) begin
            wr_hour24_o = 8'h00;
        end else if (wb == 8'd24) begin
            wr_hour24_o = 8'h12;
        end else begin
            wr_hour24_o = bin_to_bcd(wb);
        end
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4,
    parameter int ADDR_W        = 4,
    parameter int CTRL_ADDR     = 15,
    parameter int MODE_BIT      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic [7:0]        wday_o,
    output logic [7:0]        mday_o,
    output logic [7:0]        month_o,
    output logic [7:0]        year_o
);
    localparam logic [ADDR_W-1:0] FIELD_LIMIT = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] CTRL_A      = ADDR_W'(CTRL_ADDR);
    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                                   mday: 8'h01, month: 8'h01, year: 8'h00};

    cal_t   cal_q, cal_d, cal_adv;
    logic   mode24_q;
    field_e wr_field;
    logic   time_wr, ctrl_wr, sec_pulse;
    bcd8_t  hour_disp, hour_wr24;

    assign wr_field = (wr_addr_i < FIELD_LIMIT) ? field_e'(wr_addr_i[2:0]) : FLD_NONE;
    assign time_wr  = wr_en_i && (wr_field != FLD_NONE);
    assign ctrl_wr  = wr_en_i && (wr_addr_i == CTRL_A);

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .clr_i       (time_wr),
        .sec_pulse_o (sec_pulse)
    );

    cal_advance u_adv (
        .cur_i (cal_q),
        .nxt_o (cal_adv)
    );

    cal_hour_codec u_hour (
        .mode24_i    (mode24_q),
        .hour24_i    (cal_q.hour),
        .wdata_i     (wr_data_i[5:0]),
        .disp_o      (hour_disp),
        .wr_hour24_o (hour_wr24)
    );

    always_comb begin
        cal_d = cal_q;
        if (time_wr) begin
            unique case (wr_field)
                FLD_SEC:   cal_d.sec   = {1'b0, wr_data_i[6:0]};
                FLD_MIN:   cal_d.min   = {1'b0, wr_data_i[6:0]};
                FLD_HOUR:  cal_d.hour  = hour_wr24;
                FLD_WDAY:  cal_d.wday  = {5'b0, wr_data_i[2:0]};
                FLD_MDAY:  cal_d.mday  = {2'b0, wr_data_i[5:0]};
                FLD_MONTH: cal_d.month = {3'b0, wr_data_i[4:0]};
                FLD_YEAR:  cal_d.year  = wr_data_i;
                default:   cal_d       = cal_q;
            endcase
        end else if (sec_pulse) begin
            cal_d = cal_adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q    <= CAL_RESET;
            mode24_q <= 1'b0;
        end else begin
            cal_q <= cal_d;
            if (ctrl_wr) begin
                mode24_q <= wr_data_i[MODE_BIT];
            end
        end
    end

    always_comb begin
        sec_o   = cal_q.sec;
        min_o   = cal_q.min;
        hour_o  = hour_disp;
        wday_o  = cal_q.wday;
        mday_o  = cal_q.mday;
        month_o = cal_q.month;
        year_o  = cal_q.year;
    end

    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !time_wr) |=> $stable(cal_q)) else $error("time moved without second or write"); // R2
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !time_wr && cal_q.sec == 8'h59)
        |=> (cal_q.sec == 8'h00 && cal_q.min != $past(cal_q.min))) else $error("seconds wrap"); // R3
    AST_DAY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !time_wr && cal_q.sec == 8'h59 && cal_q.min == 8'h59 && cal_q.hour == 8'h23)
        |=> (cal_q.hour == 8'h00 &&
             cal_q.wday == (($past(cal_q.wday) == 8'h07) ? 8'h01 : $past(cal_q.wday) + 8'h01)))
        else $error("day carry"); // R4
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !time_wr && cal_q.sec == 8'h59 && cal_q.min == 8'h59 &&
         cal_q.hour == 8'h23 && cal_q.mday == 8'h31 && cal_q.month == 8'h12)
        |=> (cal_q.month == 8'h01 && cal_q.mday == 8'h01)) else $error("year wrap"); // R5
    AST_MODE_KEEPS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !sec_pulse) |=> $stable(cal_q)) else $error("mode write altered time"); // R12

endmodule

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;

    int checks = 0;
    int errors = 0;
    int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_pc;
    bit m_24;

    always #5 clk = ~clk;

    bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (we),
        .wr_addr_i (addr),
        .wr_data_i (wdata),
        .sec_o     (sec_o),
        .min_o     (min_o),
        .hour_o    (hour_o),
        .wday_o    (wday_o),
        .mday_o    (mday_o),
        .month_o   (month_o),
        .year_o    (year_o)
    );

    function automatic logic [7:0] tobcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int frombcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        if (m_24) return tobcd(m_h);
        if (m_h == 0) return 8'h12;
        if (m_h < 12) return tobcd(m_h);
        if (m_h == 12) return 8'h32;
        return 8'h20 | tobcd(m_h - 12);
    endfunction

    task automatic model_second();
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_mi++;
            if (m_mi == 60) begin
                m_mi = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                    m_d++;
                    if (m_d > mdays(m_mo, m_y)) begin
                        m_d = 1; m_mo++;
                        if (m_mo > 12) begin
                            m_mo = 1;
                            m_y = (m_y + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_write(int a, logic [7:0] dt);
        int t;
        if (a < 7) m_pc = 0;
        case (a)
            0: m_s  = frombcd(dt & 8'h7f);
            1: m_mi = frombcd(dt & 8'h7f);
            2: begin
                if (m_24) begin
                    m_h = frombcd(dt & 8'h3f);
                end else begin
                    t = frombcd(dt & 8'h1f) + (dt[5] ? 12 : 0);
                    if (t % 12 == 0) t -= 12;
                    m_h = t;
                end
            end
            3: m_wd = int'(dt[2:0]);
            4: m_d  = frombcd(dt & 8'h3f);
            5: m_mo = frombcd(dt & 8'h1f);
            6: m_y  = frombcd(dt);
            15: m_24 = dt[5];
            default: ;
        endcase
    endtask

    // caller sits at a falling edge; inputs held for one cycle
    task automatic cyc(logic t, logic w, int a, logic [7:0] dt);
        tick = t; we = w; addr = 4'(a); wdata = dt;
        @(negedge clk);
        tick = 1'b0; we = 1'b0;
        if (w) model_write(a, dt);
        if (t && !(w && a < 7)) begin
            m_pc++;
            if (m_pc == TPS) begin
                m_pc = 0;
                model_second();
            end
        end
    endtask

    task automatic wr(int a, logic [7:0] dt);
        cyc(1'b0, 1'b1, a, dt);
    endtask

    task automatic tk();
        cyc(1'b1, 1'b0, 0, 8'h00);
    endtask

    task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "sec",   sec_o,   tobcd(m_s));
        chk(req, "min",   min_o,   tobcd(m_mi));
        chk(req, "hour",  hour_o,  exp_hour());
        chk(req, "wday",  wday_o,  8'(m_wd));
        chk(req, "mday",  mday_o,  tobcd(m_d));
        chk(req, "month", month_o, tobcd(m_mo));
        chk(req, "year",  year_o,  tobcd(m_y));
    endtask

    task automatic set_eod(int y, int mo, int d, int wd);
        wr(15, 8'h20);
        wr(6, tobcd(y)); wr(5, tobcd(mo)); wr(4, tobcd(d)); wr(3, 8'(wd));
        wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int yrs[4] = '{23, 24, 99, 0};
        m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0; m_pc = 0; m_24 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: seconds advance only on the last tick of a group
        repeat (TPS - 1) tk();
        check_all("R2");
        tk();
        check_all("R2");
        repeat (3) @(negedge clk);
        check_all("R2");

        // R9: masks on every field
        wr(0, 8'hD8); wr(1, 8'hD9); wr(3, 8'hFD); wr(4, 8'hE8); wr(5, 8'hE2); wr(6, 8'h23);
        check_all("R9");

        // R6: 24-hour mode, hour write masked to 6 bits
        wr(15, 8'h20);
        wr(2, 8'hE3);
        check_all("R6");
        repeat (2 * TPS) tk();
        check_all("R6");

        // R3: minute and hour carries
        wr(2, 8'h05); wr(1, 8'h10); wr(0, 8'h59);
        repeat (TPS) tk();
        check_all("R3");
        wr(1, 8'h59); wr(0, 8'h59);
        repeat (TPS) tk();
        check_all("R3");

        // R4: weekday 7 wraps to 1 on day change
        set_eod(30, 3, 10, 7);
        repeat (TPS) tk();
        check_all("R4");

        // R5: every month end over leap and common years
        for (int yi = 0; yi < 4; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_eod(yrs[yi], mo, mdays(mo, yrs[yi]), mo % 7 + 1);
                repeat (TPS) tk();
                check_all("R5");
            end
        end
        set_eod(24, 2, 28, 2);
        repeat (TPS) tk();
        check_all("R5");

        // R7 and R12: display of every stored hour in 12-hour mode
        for (int h = 0; h < 24; h++) begin
            wr(15, 8'h20); wr(2, tobcd(h));
            wr(15, 8'h00);
            check_all("R7");
            wr(15, 8'h20);
            check_all("R12");
        end

        // R8: every 12-hour write value
        for (int pm = 0; pm < 2; pm++) begin
            for (int hv = 1; hv <= 12; hv++) begin
                wr(15, 8'h00);
                wr(2, (pm != 0 ? 8'h20 : 8'h00) | tobcd(hv));
                check_all("R8");
                wr(15, 8'h20);
                check_all("R8");
            end
        end

        // R7: 11:59:59 AM rolls to noon in 12-hour mode
        wr(15, 8'h00); wr(2, 8'h11); wr(1, 8'h59); wr(0, 8'h59);
        repeat (TPS) tk();
        check_all("R7");

        // R10: field write clears prescaler; control write does not
        wr(0, 8'h10);
        repeat (TPS - 1) tk();
        wr(1, 8'h20);
        repeat (TPS - 1) tk();
        check_all("R10");
        tk();
        check_all("R10");
        repeat (TPS - 1) tk();
        cyc(1'b1, 1'b1, 0, 8'h30);
        check_all("R10");
        repeat (TPS - 1) tk();
        check_all("R10");
        tk();
        check_all("R10");
        repeat (TPS - 1) tk();
        wr(15, 8'h20);
        tk();
        check_all("R10");

        // R11: reserved addresses ignored
        for (int a = 7; a < 15; a++) begin
            wr(a, 8'hFF);
            check_all("R11");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule